// File: doc/BRIEF.md
# Seconds Counter with Alarm and Watchdog

This block is a memory-mapped real-time-clock peripheral on a plain 32-bit register bus. It keeps a seconds count that advances on an external 1 Hz tick. It compares that count against an alarm value and raises an interrupt and a wake flag on a match. It also runs a countdown watchdog that emits a one-cycle reset pulse when it expires. The seconds and alarm registers sit behind a commit stage that models a write into a slow always-on domain. Until the commit lands, a per-register stale flag in the status word stays set and reads still return the old value.

The control register and the two persistent registers each have a plain write address, a write-one-to-set alias and a write-one-to-clear alias. Software can change single bits without a read-modify-write. Reads are combinational on the address. Writes take effect at the clock edge where `we_i` is high.

Top module: `rtc_regblk`

## Requirements
- R1: After reset, the status word (0x10) reads 0x8000_0000, with bit 31 as the presence flag. Control (0x00), seconds (0x30), alarm (0x40), watchdog timeout (0x50) and both persistent registers (0x60, 0x70) read 0.
- R2: A write to a base address replaces the implemented bits and all other bits read 0. Control implements bit 0 (alarm irq enable), bit 1 (millisecond irq enable), bit 2 (alarm pending) and bit 4 (watchdog enable), so writing all ones reads back 0x17. Persistent0 implements bit 1 (wake enable), bit 2 (alarm enable) and bit 7 (wake flag), giving 0x86. Persistent1 implements bit 31 (force update), giving 0x8000_0000.
- R3: A write to a set alias (control 0x04, persistent0 0x64) ORs the written bits into the register. A write to a clear alias (control 0x08, persistent0 0x68) removes the written bits. No other bit changes.
- R4: A write to seconds sets status bit 23 at the write edge. Bit 23 clears 4 clock edges later, and the new value is committed at that same edge. Until then, seconds reads return the previous value.
- R5: A write to alarm follows the same 4-edge commit, with status bit 22 as its stale flag.
- R6: Each clock edge with `tick_i` high increments the seconds count by one.
- R7: When a tick makes the seconds count equal the alarm value and persistent0 bit 2 is set, control bit 2 (pending) is set. Persistent0 bit 7 (wake) is set only if persistent0 bit 1 is also set. With persistent0 bit 2 clear, neither flag is set.
- R8: `alarm_irq_o` equals control bit 2 ANDed with control bit 0.
- R9: Writing 0x4 to 0x08 clears the pending flag, and writing 0x80 to 0x68 clears the wake flag.
- R10: While control bit 4 is set, each tick decrements a non-zero timeout count, which is readable at 0x50. The step from 1 to 0 drives `wdog_rst_o` high for exactly one cycle. A count of 0 never pulses. Writing 0x50 reloads the count. With bit 4 clear, the count holds.
- R11: Writes to the status address are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 8 | Register byte address |
| we_i | input | 1 | Write strobe, sampled at the rising edge |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational on addr_i |
| tick_i | input | 1 | One-cycle 1 Hz tick |
| alarm_irq_o | output | 1 | Alarm interrupt |
| wdog_rst_o | output | 1 | One-cycle watchdog reset pulse |

## Verification
Register writes, set/clear aliases and ticks act at the edge where the strobe is high. The bench drives each stimulus on the falling edge and reads the result on the next falling edge. The interrupt output is combinational on the pending flag, so it is checked in the same half cycle as the flag. Commits of seconds and alarm land on the fourth edge after the write. The bench samples the stale flag and the old value after each of edges one to three and the new value after edge four. The watchdog pulse is registered at the edge of the tick that reaches zero, so it is checked right after that edge and again one cycle later, when it must be low.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] A_CTRL     = 8'h00;
  localparam logic [ADDR_W-1:0] A_CTRL_SET = 8'h04;
  localparam logic [ADDR_W-1:0] A_CTRL_CLR = 8'h08;
  localparam logic [ADDR_W-1:0] A_STAT     = 8'h10;
  localparam logic [ADDR_W-1:0] A_SEC      = 8'h30;
  localparam logic [ADDR_W-1:0] A_ALM      = 8'h40;
  localparam logic [ADDR_W-1:0] A_WDOG     = 8'h50;
  localparam logic [ADDR_W-1:0] A_P0       = 8'h60;
  localparam logic [ADDR_W-1:0] A_P0_SET   = 8'h64;
  localparam logic [ADDR_W-1:0] A_P0_CLR   = 8'h68;
  localparam logic [ADDR_W-1:0] A_P1       = 8'h70;

  // control bits
  localparam int C_IRQ_EN  = 0;
  localparam int C_MS_EN   = 1;
  localparam int C_PEND    = 2;
  localparam int C_WDOG_EN = 4;
  // persistent0 bits
  localparam int P_WAKE_EN = 1;
  localparam int P_ALM_EN  = 2;
  localparam int P_WAKE    = 7;
  // persistent1 bits
  localparam int P1_FORCE  = 31;

  localparam logic [DATA_W-1:0] CTRL_MASK = 32'h0000_0017;
  localparam logic [DATA_W-1:0] P0_MASK   = 32'h0000_0086;
  localparam logic [DATA_W-1:0] P1_MASK   = 32'h8000_0000;

  // status layout
  localparam int S_STALE_BASE = 16;
  localparam int S_STALE_ALM  = S_STALE_BASE + 6;
  localparam int S_STALE_SEC  = S_STALE_BASE + 7;
  localparam int S_PRESENT    = 31;
endpackage

// File: rtl/rtc_setclr.sv
module rtc_setclr #(
  parameter int W = 32,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic         set_i,
  input  logic         clr_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] hw_set_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q, sw_nxt;

  always_comb begin
    sw_nxt = q;
    if (wr_i)       sw_nxt = wdata_i & MASK;
    else if (set_i) sw_nxt = q | (wdata_i & MASK);
    else if (clr_i) sw_nxt = q & ~wdata_i;
  end

  // hardware set wins over a same-cycle software clear
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) q <= '0;
    else         q <= sw_nxt | (hw_set_i & MASK);

  assign q_o = q;

  a_r3_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && !set_i && !clr_i && hw_set_i == '0) |=> $stable(q_o));
endmodule

// File: rtl/rtc_shadow.sv
module rtc_shadow #(
  parameter int W   = 32,
  parameter int LAT = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic         stale_o,
  output logic         commit_o,
  output logic [W-1:0] commit_data_o
);
  localparam int CNT_W = $clog2(LAT + 1);

  logic [CNT_W-1:0] cnt;
  logic [W-1:0]     hold;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      cnt  <= '0;
      hold <= '0;
    end else if (wr_i) begin
      cnt  <= CNT_W'(LAT);
      hold <= wdata_i;
    end else if (cnt != '0) begin
      cnt  <= cnt - 1'b1;
    end

  assign stale_o       = (cnt != '0);
  assign commit_o      = (cnt == CNT_W'(1)) && !wr_i;
  assign commit_data_o = hold;

  a_r4_stale_after_wr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> stale_o);
  a_r4_commit_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |=> !stale_o);
endmodule

// File: rtl/rtc_wdog.sv
module rtc_wdog #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         en_i,
  input  logic         tick_i,
  output logic [W-1:0] cnt_o,
  output logic         rst_o
);
  logic [W-1:0] cnt;
  logic         pulse;
  logic         step;

  assign step = en_i && tick_i && (cnt != '0) && !load_i;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      cnt   <= '0;
      pulse <= 1'b0;
    end else begin
      if (load_i)    cnt <= load_val_i;
      else if (step) cnt <= cnt - 1'b1;
      pulse <= step && (cnt == W'(1));
    end

  assign cnt_o = cnt;
  assign rst_o = pulse;

  a_r10_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_o |=> !rst_o);
  a_r10_pulse_at_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_o && !$past(load_i)) |-> (cnt_o == '0));
endmodule

// File: rtl/rtc_regblk.sv
module rtc_regblk
  import rtc_pkg::*;
#(
  parameter int COMMIT_LAT = 4,
  parameter int SEC_W      = 32,
  parameter int WDOG_W     = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              tick_i,
  output logic              alarm_irq_o,
  output logic              wdog_rst_o
);
  logic [DATA_W-1:0] ctrl_q, p0_q, p1_q;
  logic [DATA_W-1:0] ctrl_hw, p0_hw;
  logic [SEC_W-1:0]  sec_q, alm_q, sec_nxt, sec_cd, alm_cd;
  logic [WDOG_W-1:0] wd_cnt;
  logic              sec_stale, alm_stale, sec_cmt, alm_cmt;
  logic              match;

  // bus decode
  logic wr_ctrl, set_ctrl, clr_ctrl, wr_p0, set_p0, clr_p0, wr_p1;
  logic wr_sec, wr_alm, wr_wd;
  assign wr_ctrl  = we_i && addr_i == A_CTRL;
  assign set_ctrl = we_i && addr_i == A_CTRL_SET;
  assign clr_ctrl = we_i && addr_i == A_CTRL_CLR;
  assign wr_p0    = we_i && addr_i == A_P0;
  assign set_p0   = we_i && addr_i == A_P0_SET;
  assign clr_p0   = we_i && addr_i == A_P0_CLR;
  assign wr_p1    = we_i && addr_i == A_P1;
  assign wr_sec   = we_i && addr_i == A_SEC;
  assign wr_alm   = we_i && addr_i == A_ALM;
  assign wr_wd    = we_i && addr_i == A_WDOG;

  rtc_shadow #(.W(SEC_W), .LAT(COMMIT_LAT)) u_sec_sh (
    .clk_i, .rst_ni, .wr_i(wr_sec), .wdata_i(wdata_i[SEC_W-1:0]),
    .stale_o(sec_stale), .commit_o(sec_cmt), .commit_data_o(sec_cd));

  rtc_shadow #(.W(SEC_W), .LAT(COMMIT_LAT)) u_alm_sh (
    .clk_i, .rst_ni, .wr_i(wr_alm), .wdata_i(wdata_i[SEC_W-1:0]),
    .stale_o(alm_stale), .commit_o(alm_cmt), .commit_data_o(alm_cd));

  // seconds / alarm committed state
  assign sec_nxt = sec_q + 1'b1;
  assign match   = tick_i && !sec_cmt && p0_q[P_ALM_EN] && (sec_nxt == alm_q);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      sec_q <= '0;
      alm_q <= '0;
    end else begin
      if (sec_cmt)     sec_q <= sec_cd;
      else if (tick_i) sec_q <= sec_nxt;
      if (alm_cmt)     alm_q <= alm_cd;
    end

  always_comb begin
    ctrl_hw         = '0;
    p0_hw           = '0;
    ctrl_hw[C_PEND] = match;
    p0_hw[P_WAKE]   = match && p0_q[P_WAKE_EN];
  end

  rtc_setclr #(.W(DATA_W), .MASK(CTRL_MASK)) u_ctrl (
    .clk_i, .rst_ni, .wr_i(wr_ctrl), .set_i(set_ctrl), .clr_i(clr_ctrl),
    .wdata_i, .hw_set_i(ctrl_hw), .q_o(ctrl_q));

  rtc_setclr #(.W(DATA_W), .MASK(P0_MASK)) u_p0 (
    .clk_i, .rst_ni, .wr_i(wr_p0), .set_i(set_p0), .clr_i(clr_p0),
    .wdata_i, .hw_set_i(p0_hw), .q_o(p0_q));

  rtc_setclr #(.W(DATA_W), .MASK(P1_MASK)) u_p1 (
    .clk_i, .rst_ni, .wr_i(wr_p1), .set_i(1'b0), .clr_i(1'b0),
    .wdata_i, .hw_set_i('0), .q_o(p1_q));

  rtc_wdog #(.W(WDOG_W)) u_wdog (
    .clk_i, .rst_ni, .load_i(wr_wd), .load_val_i(wdata_i[WDOG_W-1:0]),
    .en_i(ctrl_q[C_WDOG_EN]), .tick_i, .cnt_o(wd_cnt), .rst_o(wdog_rst_o));

  assign alarm_irq_o = ctrl_q[C_PEND] & ctrl_q[C_IRQ_EN];

  // read mux
  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_CTRL: rdata_o = ctrl_q;
      A_STAT: begin
        rdata_o[S_PRESENT]   = 1'b1;
        rdata_o[S_STALE_SEC] = sec_stale;
        rdata_o[S_STALE_ALM] = alm_stale;
      end
      A_SEC:  rdata_o = DATA_W'(sec_q);
      A_ALM:  rdata_o = DATA_W'(alm_q);
      A_WDOG: rdata_o = DATA_W'(wd_cnt);
      A_P0:   rdata_o = p0_q;
      A_P1:   rdata_o = p1_q;
      default: rdata_o = '0;
    endcase
  end

  a_r7_wake_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(p0_q[P_WAKE]) && !$past(we_i)) |-> $past(tick_i && p0_q[P_WAKE_EN] && p0_q[P_ALM_EN]));
  a_r7_pend_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(ctrl_q[C_PEND]) && !$past(we_i)) |-> $past(tick_i && p0_q[P_ALM_EN]));
endmodule

// File: tb/rtc_regblk_tb.sv
`timescale 1ns/1ps
module rtc_regblk_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        tick = 1'b0;
  logic        irq, wrst;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  rtc_regblk u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .tick_i(tick), .alarm_irq_o(irq), .wdog_rst_o(wrst));

  typedef struct packed {
    logic        rd;
    logic [7:0]  a;
    logic [31:0] d;
    logic [3:0]  r;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 8'h10, 32'h8000_0000, 4'd1},  // R1
    '{1'b1, 8'h00, 32'h0,         4'd1},  // R1
    '{1'b1, 8'h30, 32'h0,         4'd1},  // R1
    '{1'b1, 8'h60, 32'h0,         4'd1},  // R1
    '{1'b0, 8'h00, 32'hFFFF_FFFF, 4'd2},
    '{1'b1, 8'h00, 32'h17,        4'd2},  // R2
    '{1'b0, 8'h08, 32'h6,         4'd3},
    '{1'b1, 8'h00, 32'h11,        4'd3},  // R3
    '{1'b0, 8'h04, 32'h2,         4'd3},
    '{1'b1, 8'h00, 32'h13,        4'd3},  // R3
    '{1'b0, 8'h00, 32'h0,         4'd2},
    '{1'b0, 8'h60, 32'hFFFF_FFFF, 4'd2},
    '{1'b1, 8'h60, 32'h86,        4'd2},  // R2
    '{1'b0, 8'h68, 32'h84,        4'd3},
    '{1'b1, 8'h60, 32'h02,        4'd3},  // R3
    '{1'b0, 8'h70, 32'hFFFF_FFFF, 4'd2},
    '{1'b1, 8'h70, 32'h8000_0000, 4'd2},  // R2
    '{1'b0, 8'h10, 32'h0000_0000, 4'd11},
    '{1'b1, 8'h10, 32'h8000_0000, 4'd11}, // R11
    '{1'b0, 8'h68, 32'h02,        4'd3}
  };

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic tk();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
    addr = a;
    #1;
    n_chk++;
    if (rdata !== exp) begin
      n_bad++;
      $display("FAIL %s addr %h: got %h expected %h", tag, a, rdata, exp);
    end
  endtask

  task automatic chk1(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // table walk: reset values, base writes, aliases, read-only status
    for (int i = 0; i < NV; i++) begin
      if (VEC[i].rd) begin
        @(negedge clk);
        chk(VEC[i].a, VEC[i].d, $sformatf("R%0d vec%0d", VEC[i].r, i));
      end else begin
        wr(VEC[i].a, VEC[i].d);
      end
    end

    // R4: seconds commit window
    wr(8'h30, 32'd100);
    chk(8'h10, 32'h8080_0000, "R4 stale set");
    chk(8'h30, 32'd0, "R4 old value");
    for (int i = 1; i < 4; i++) begin
      @(negedge clk);
      chk(8'h10, 32'h8080_0000, "R4 stale held");
      chk(8'h30, 32'd0, "R4 old held");
    end
    @(negedge clk);
    chk(8'h10, 32'h8000_0000, "R4 stale clear");
    chk(8'h30, 32'd100, "R4 committed");

    // R6
    tk();
    chk(8'h30, 32'd101, "R6 tick");

    // R5: alarm commit window
    wr(8'h40, 32'd103);
    chk(8'h10, 32'h8040_0000, "R5 stale set");
    chk(8'h40, 32'd0, "R5 old value");
    repeat (4) @(negedge clk);
    chk(8'h10, 32'h8000_0000, "R5 stale clear");
    chk(8'h40, 32'd103, "R5 committed");

    // R7/R8 alarm match with wake
    wr(8'h64, 32'h6);
    wr(8'h04, 32'h1);
    tk();
    chk(8'h00, 32'h1, "R7 no early match");
    chk1(irq, 1'b0, "R8 irq low");
    tk();
    chk(8'h00, 32'h5, "R7 pending set");
    chk(8'h60, 32'h86, "R7 wake set");
    chk1(irq, 1'b1, "R8 irq high");
    wr(8'h08, 32'h1);
    chk1(irq, 1'b0, "R8 irq masked");
    chk(8'h00, 32'h4, "R8 pending kept");

    // R9
    wr(8'h08, 32'h4);
    chk(8'h00, 32'h0, "R9 pending cleared");
    wr(8'h68, 32'h80);
    chk(8'h60, 32'h06, "R9 wake cleared");

    // R7: alarm enable clear blocks match
    wr(8'h68, 32'h4);
    wr(8'h30, 32'd102);
    repeat (4) @(negedge clk);
    tk();
    chk(8'h30, 32'd103, "R7 count at alarm");
    chk(8'h00, 32'h0, "R7 disabled no pend");
    chk(8'h60, 32'h02, "R7 disabled no wake");

    // R7: match without wake enable
    wr(8'h68, 32'h2);
    wr(8'h64, 32'h4);
    wr(8'h30, 32'd102);
    repeat (4) @(negedge clk);
    tk();
    chk(8'h00, 32'h4, "R7 pend no wake_en");
    chk(8'h60, 32'h04, "R7 wake gated");
    wr(8'h08, 32'h4);

    // R10 watchdog
    wr(8'h50, 32'd3);
    wr(8'h04, 32'h10);
    chk(8'h50, 32'd3, "R10 loaded");
    tk();
    tk();
    chk(8'h50, 32'd1, "R10 decrement");
    chk1(wrst, 1'b0, "R10 no early pulse");
    tk();
    chk1(wrst, 1'b1, "R10 pulse");
    chk(8'h50, 32'd0, "R10 at zero");
    @(negedge clk);
    chk1(wrst, 1'b0, "R10 pulse one cycle");
    tk();
    chk1(wrst, 1'b0, "R10 zero quiet");
    chk(8'h50, 32'd0, "R10 zero holds");
    wr(8'h50, 32'd5);
    tk();
    chk(8'h50, 32'd4, "R10 reload");
    wr(8'h08, 32'h10);
    tk();
    chk(8'h50, 32'd4, "R10 disabled holds");

    // R1: reset mid-run
    @(negedge clk);
    rst_ni = 1'b0;
    chk(8'h10, 32'h8000_0000, "R1 status after reset");
    chk(8'h30, 32'd0, "R1 seconds after reset");
    chk(8'h50, 32'd0, "R1 timeout after reset");
    chk(8'h40, 32'd0, "R1 alarm after reset");
    @(negedge clk);
    rst_ni = 1'b1;

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule